// File: doc/BRIEF.md
# BCD Reloading Watchdog Countdown

This block is a watchdog timer whose period is held as four BCD digits in two 8-bit registers, so software enters a time from 00.00 to 99.99 seconds directly in decimal. An internal copy of the period counts down by one hundredth on every pulse of a 100 Hz tick. When the countdown expires, the block raises its watchdog flag, drives an interrupt and reloads itself, so an unattended watchdog fires again each period. Software keeps the alarm from firing by touching either register often enough: a read or a write restarts the countdown from the entered value and clears the flag.

The interrupt can hold until the next register access (level mode) or self-clear after a minimum active time counted on a 4096 Hz enable (pulse mode). A mask input silences the watchdog interrupt without touching the flag. The block also drives the two interrupt outputs of the timekeeper. A swap input decides which output carries the watchdog and which carries a second alarm request from a neighbouring block. A polarity input selects the active level of the second output.

Top module: `wdog_bcd_timer`

## Requirements
- R1: After reset both period registers read 0x00, `wd_flag` is 0, `irq_a_n` is 1 and `irq_b` is at its inactive level.
- R2: `reg_sel`=0 addresses the hundredths register (tenths digit in bits 7:4, hundredths digit in bits 3:0). `reg_sel`=1 addresses the seconds register (tens-of-seconds digit in bits 7:4, units digit in bits 3:0). A read always returns the entered value, never the running count.
- R3: Any access (`reg_en`=1, read or write) to either register reloads the countdown from the entered value and clears `wd_flag` in the next cycle.
- R4: With a nonzero period of N hundredths, `wd_flag` rises after the N-th 100 Hz tick following the last access. The countdown borrows across BCD digits, so 01.00 takes 100 ticks.
- R5: Without any access, the countdown reloads on expiry and times out again every N ticks.
- R6: A period of 00.00 disables the watchdog: `wd_flag` never sets.
- R7: In pulse mode (`cfg_pulse`=1), the flag and the watchdog interrupt stay active for 13 pulses of `tick_4khz`, about 3.2 ms, and then clear. In level mode (`cfg_pulse`=0), they stay active until the next register access.
- R8: `cfg_mask`=1 holds the watchdog interrupt inactive and has no effect on `wd_flag`.
- R9: `cfg_swap`=1 routes the other alarm (`tod_irq`) to output A and the watchdog to output B. `cfg_swap`=0 routes the watchdog to A and the other alarm to B. The routing follows the input in the same cycle, including for outputs that are already active.
- R10: Output A is active low. Output B is active high when `cfg_b_high`=1 and active low when `cfg_b_high`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register access strobe, one cycle per access |
| reg_wr | input | 1 | 1 = write, 0 = read, qualified by reg_en |
| reg_sel | input | 1 | 0 = hundredths register, 1 = seconds register |
| reg_wdata | input | 8 | Write data, two BCD digits |
| reg_rdata | output | 8 | Entered value of the selected register |
| tick_100hz | input | 1 | One-cycle countdown enable at 100 Hz |
| tick_4khz | input | 1 | One-cycle pulse timebase enable at 4096 Hz |
| cfg_pulse | input | 1 | 1 = pulse mode, 0 = level mode |
| cfg_mask | input | 1 | 1 = watchdog interrupt held inactive |
| cfg_swap | input | 1 | Interrupt source routing select |
| cfg_b_high | input | 1 | 1 = output B active high |
| tod_irq | input | 1 | Other alarm request, active high |
| wd_flag | output | 1 | Watchdog flag |
| irq_a_n | output | 1 | Interrupt output A, active low |
| irq_b | output | 1 | Interrupt output B, polarity per cfg_b_high |

## Verification
The assertions assume that each access is a single-cycle `reg_en` strobe and that both timebases arrive as single-cycle enables. They also assume that written periods contain only decimal digits, because the expected tick counts depend on BCD borrow behaviour. The stimulus tasks raise every strobe at one falling edge and drop it at the next, and they write only values made of digits 0 to 9. The `tick_4khz` pulses are issued in bursts, with no 100 Hz tick in the same cycle, so that the end of a pulse and a fresh expiry never coincide.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int WDT_DIGITS_DEF = 4;
    localparam int WDT_PULSE_DEF  = 13;

    typedef enum logic {
        OUT_LEVEL = 1'b0,
        OUT_PULSE = 1'b1
    } irq_mode_e;
endpackage

// File: rtl/wdt_bcd_dec.sv
module wdt_bcd_dec #(
    parameter int DIGITS = 4
) (
    input  logic [4*DIGITS-1:0] val,
    output logic [4*DIGITS-1:0] dec,
    output logic                is_one
);
    logic [DIGITS-1:0] borrow;

    assign borrow[0] = 1'b1;

    generate
        for (genvar g = 0; g < DIGITS; g++) begin : g_digit
            logic [3:0] dig;
            assign dig = val[4*g +: 4];
            assign dec[4*g +: 4] = !borrow[g] ? dig :
                                   (dig == 4'd0) ? 4'd9 : dig - 4'd1;
            if (g + 1 < DIGITS) begin : g_chain
                assign borrow[g+1] = borrow[g] && (dig == 4'd0);
            end
        end
    endgenerate

    assign is_one = (val == {{(4*DIGITS-1){1'b0}}, 1'b1});
endmodule

// File: rtl/wdt_pulse_timer.sv
module wdt_pulse_timer #(
    parameter int TICKS = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(TICKS + 1);
    localparam logic [CW-1:0] LOAD = CW'(TICKS);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        done  = 1'b0;
        if (abort) begin
            cnt_d = '0;
        end else if (start) begin
            cnt_d = LOAD;
        end else if (tick && cnt_q != '0) begin
            cnt_d = cnt_q - CW'(1);
            done  = (cnt_q == CW'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_PULSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !start && !abort) |=> $stable(cnt_q)); // R7
    AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q <= LOAD)); // R7
endmodule

// File: rtl/wdt_irq_route.sv
module wdt_irq_route (
    input  logic wd_act,
    input  logic tod_act,
    input  logic swap,
    input  logic b_high,
    output logic irq_a_n,
    output logic irq_b
);
    logic a_act, b_act;

    always_comb begin
        a_act   = swap ? tod_act : wd_act;
        b_act   = swap ? wd_act  : tod_act;
        irq_a_n = !a_act;
        irq_b   = b_high ? b_act : !b_act;
    end

    always_comb begin
        AST_BOTH_ON_A: assert (!(wd_act && tod_act) || !irq_a_n); // R9
        AST_BOTH_OFF_B: assert ((wd_act || tod_act) || (irq_b == !b_high)); // R10
    end
endmodule

// File: rtl/wdog_bcd_timer.sv
module wdog_bcd_timer #(
    parameter int DIGITS      = wdt_pkg::WDT_DIGITS_DEF,
    parameter int PULSE_TICKS = wdt_pkg::WDT_PULSE_DEF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_en,
    input  logic       reg_wr,
    input  logic       reg_sel,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       tick_100hz,
    input  logic       tick_4khz,
    input  logic       cfg_pulse,
    input  logic       cfg_mask,
    input  logic       cfg_swap,
    input  logic       cfg_b_high,
    input  logic       tod_irq,
    output logic       wd_flag,
    output logic       irq_a_n,
    output logic       irq_b
);
    import wdt_pkg::*;

    localparam int PW = 4 * DIGITS;

    typedef struct packed {
        logic [PW-1:0] period;
        logic [PW-1:0] count;
        logic          flag;
    } wdt_state_t;

    wdt_state_t s_d, s_q;
    irq_mode_e  mode;
    logic [PW-1:0] cnt_dec, new_period;
    logic cnt_one, timeout, pulse_done, per_zero;

    assign mode     = irq_mode_e'(cfg_pulse);
    assign per_zero = (s_q.period == '0);

    wdt_bcd_dec #(.DIGITS(DIGITS)) i_dec (
        .val    (s_q.count),
        .dec    (cnt_dec),
        .is_one (cnt_one)
    );

    wdt_pulse_timer #(.TICKS(PULSE_TICKS)) i_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .start (timeout),
        .abort (reg_en),
        .tick  (tick_4khz),
        .done  (pulse_done)
    );

    always_comb begin
        new_period = s_q.period;
        if (reg_en && reg_wr) new_period[8*reg_sel +: 8] = reg_wdata;

        s_d     = s_q;
        timeout = 1'b0;
        if (reg_en) begin
            s_d.period = new_period;
            s_d.count  = new_period;
            s_d.flag   = 1'b0;
        end else begin
            if (tick_100hz && !per_zero) begin
                if (cnt_one) begin
                    timeout   = 1'b1;
                    s_d.count = s_q.period;
                    s_d.flag  = 1'b1;
                end else begin
                    s_d.count = cnt_dec;
                end
            end
            if (!timeout && pulse_done && mode == OUT_PULSE) s_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign reg_rdata = s_q.period[8*reg_sel +: 8];
    assign wd_flag   = s_q.flag;

    wdt_irq_route i_route (
        .wd_act  (s_q.flag && !cfg_mask),
        .tod_act (tod_irq),
        .swap    (cfg_swap),
        .b_high  (cfg_b_high),
        .irq_a_n (irq_a_n),
        .irq_b   (irq_b)
    );

    AST_ACCESS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        reg_en |=> !wd_flag); // R3
    AST_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && !reg_wr) |=> $stable(s_q.period)); // R2
    AST_COUNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.period != '0) |-> (s_q.count != '0)); // R4
    AST_IDLE_NO_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
        (per_zero && !s_q.flag) |=> !s_q.flag); // R6
    AST_PULSE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == OUT_PULSE && pulse_done && !reg_en && !tick_100hz) |=> !s_q.flag); // R7
    AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mask && !cfg_swap) |-> irq_a_n); // R8
endmodule

// File: tb/test_wdog_bcd_timer.sv
module test_wdog_bcd_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_en = 1'b0, reg_wr = 1'b0, reg_sel = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       tick_100hz = 1'b0, tick_4khz = 1'b0;
    logic       cfg_pulse = 1'b0, cfg_mask = 1'b0, cfg_swap = 1'b0, cfg_b_high = 1'b0;
    logic       tod_irq = 1'b0;
    logic       wd_flag, irq_a_n, irq_b;
    int         checks = 0, fails = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    wdog_bcd_timer i_wdog_bcd_timer (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tick_100hz(tick_100hz), .tick_4khz(tick_4khz), .cfg_pulse(cfg_pulse),
        .cfg_mask(cfg_mask), .cfg_swap(cfg_swap), .cfg_b_high(cfg_b_high),
        .tod_irq(tod_irq), .wd_flag(wd_flag), .irq_a_n(irq_a_n), .irq_b(irq_b)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic access(input logic sel, input logic wr, input logic [7:0] d,
                          output logic [7:0] rd);
        @(negedge clk);
        reg_sel = sel; reg_wr = wr; reg_wdata = d; reg_en = 1'b1;
        #1 rd = reg_rdata;
        @(negedge clk);
        reg_en = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic set_period(input logic [7:0] secs, input logic [7:0] frac);
        logic [7:0] rd;
        access(1'b0, 1'b1, frac, rd);
        access(1'b1, 1'b1, secs, rd);
    endtask

    task automatic tick100(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick_100hz = 1'b1;
            @(negedge clk) tick_100hz = 1'b0;
        end
    endtask

    task automatic tick4k(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick_4khz = 1'b1;
            @(negedge clk) tick_4khz = 1'b0;
        end
    endtask

    task automatic t_reset;
        logic [7:0] rd;
        chk("R1 flag", {7'd0, wd_flag}, 8'h00);
        chk("R1 irq_a_n", {7'd0, irq_a_n}, 8'h01);
        chk("R1 irq_b", {7'd0, irq_b}, 8'h01);
        access(1'b0, 1'b0, 8'h00, rd); chk("R1 frac reg", rd, 8'h00);
        access(1'b1, 1'b0, 8'h00, rd); chk("R1 secs reg", rd, 8'h00);
    endtask

    task automatic t_regs;
        logic [7:0] rd;
        set_period(8'h42, 8'h25);
        tick100(7);
        access(1'b0, 1'b0, 8'h00, rd); chk("R2 frac readback", rd, 8'h25);
        access(1'b1, 1'b0, 8'h00, rd); chk("R2 secs readback", rd, 8'h42);
    endtask

    task automatic t_timeout_level;
        logic [7:0] rd;
        set_period(8'h00, 8'h05);
        tick100(4); chk("R4 before expiry", {7'd0, wd_flag}, 8'h00);
        tick100(1); chk("R4 at expiry", {7'd0, wd_flag}, 8'h01);
        chk("R10 A active low", {7'd0, irq_a_n}, 8'h00);
        tick100(12); tick4k(20);
        chk("R7 level holds", {7'd0, wd_flag}, 8'h01);
        access(1'b1, 1'b0, 8'h00, rd);
        chk("R3 read clears flag", {7'd0, wd_flag}, 8'h00);
        chk("R3 output released", {7'd0, irq_a_n}, 8'h01);
    endtask

    task automatic t_borrow;
        set_period(8'h01, 8'h00);
        tick100(99); chk("R4 borrow 99", {7'd0, wd_flag}, 8'h00);
        tick100(1);  chk("R4 borrow 100", {7'd0, wd_flag}, 8'h01);
    endtask

    task automatic t_restart;
        logic [7:0] rd;
        set_period(8'h00, 8'h10);
        tick100(7);
        access(1'b0, 1'b0, 8'h00, rd); chk("R2 not live count", rd, 8'h10);
        tick100(9); chk("R3 restarted", {7'd0, wd_flag}, 8'h00);
        tick100(1); chk("R3 full period", {7'd0, wd_flag}, 8'h01);
    endtask

    task automatic t_disable;
        logic [7:0] rd;
        set_period(8'h00, 8'h00);
        tick100(150); chk("R6 disabled", {7'd0, wd_flag}, 8'h00);
        access(1'b0, 1'b0, 8'h00, rd); chk("R6 zero kept", rd, 8'h00);
    endtask

    task automatic t_pulse;
        cfg_pulse = 1'b1;
        set_period(8'h00, 8'h03);
        tick100(3); chk("R7 pulse start", {7'd0, wd_flag}, 8'h01);
        chk("R7 pulse output", {7'd0, irq_a_n}, 8'h00);
        tick4k(12); chk("R7 pulse 12", {7'd0, wd_flag}, 8'h01);
        tick4k(1);  chk("R7 pulse end", {7'd0, wd_flag}, 8'h00);
        chk("R7 output released", {7'd0, irq_a_n}, 8'h01);
        tick100(2); chk("R5 no early repeat", {7'd0, wd_flag}, 8'h00);
        tick100(1); chk("R5 repeat", {7'd0, wd_flag}, 8'h01);
        tick4k(13); chk("R5 repeat pulse end", {7'd0, wd_flag}, 8'h00);
        cfg_pulse = 1'b0;
    endtask

    task automatic t_mask;
        cfg_mask = 1'b1;
        set_period(8'h00, 8'h02);
        tick100(2);
        chk("R8 flag unaffected", {7'd0, wd_flag}, 8'h01);
        chk("R8 output masked", {7'd0, irq_a_n}, 8'h01);
        cfg_mask = 1'b0; #1;
        chk("R8 unmasked", {7'd0, irq_a_n}, 8'h00);
    endtask

    task automatic t_swap_pol;
        logic [7:0] rd;
        cfg_swap = 1'b1; #1;
        chk("R9 swap A", {7'd0, irq_a_n}, 8'h01);
        chk("R10 B active low", {7'd0, irq_b}, 8'h00);
        cfg_b_high = 1'b1; #1;
        chk("R10 B active high", {7'd0, irq_b}, 8'h01);
        cfg_swap = 1'b0; #1;
        chk("R9 unswap B idle", {7'd0, irq_b}, 8'h00);
        tod_irq = 1'b1; #1;
        chk("R9 tod on B", {7'd0, irq_b}, 8'h01);
        access(1'b0, 1'b0, 8'h00, rd);
        cfg_swap = 1'b1; #1;
        chk("R9 tod on A", {7'd0, irq_a_n}, 8'h00);
        chk("R9 B idle high mode", {7'd0, irq_b}, 8'h00);
        tod_irq = 1'b0; cfg_swap = 1'b0; cfg_b_high = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 t_reset_pre();
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_timeout_level();
        t_borrow();
        t_restart();
        t_disable();
        t_pulse();
        t_mask();
        t_swap_pol();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    task automatic t_reset_pre;
        chk("R1 flag in reset", {7'd0, wd_flag}, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule